// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Logic Unit with Sign and Zero Flags

This block is the combinational arithmetic logic unit of a small multicycle processor. It takes two 16-bit operands, `opa` and `opb`, and a 4-bit function code. It returns a 16-bit result and two status bits: one marks a negative result and one marks a zero result. The controller of the processor picks the function code each cycle. Registers and operand selection sit around this block, and the result is valid in the same cycle the inputs are applied.

Addition, subtraction and the signed less-than test all go through one carry chain. The chain is a row of identical one-bit full-adder slices. For subtraction and for the compare, the second operand is inverted and the first carry-in is forced to one. The compare uses the sign of the true difference: the sign bit of the chain output is corrected by the overflow condition. Function codes that have no operation give an all-zero result.

Top module: `alu16_core`

## Requirements
- R1: Function code 0 drives `res` with `opa + opb` modulo 2^16.
- R2: Function code 1 drives `res` with `opa - opb` modulo 2^16.
- R3: Function code 2 drives `res` with the bitwise AND of the operands.
- R4: Function code 3 drives `res` with the bitwise OR of the operands.
- R5: Function code 4 drives `res` with 1 when `opa` is less than `opb` as two's-complement signed values and 0 otherwise. The answer is correct even when `opa - opb` overflows, and bits 15 to 1 of `res` are always zero.
- R6: Function codes 5 to 15 drive `res` with zero, whatever the operands are.
- R7: `flag_z` is 1 exactly when all 16 bits of `res` are zero, and this holds for every function code.
- R8: `flag_n` always equals bit 15 of `res`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand (minuend for subtract and compare) |
| opb | input | 16 | Second operand |
| fn | input | 4 | Function code: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed less-than, 5 to 15 zero |
| res | output | 16 | Result |
| flag_n | output | 1 | Negative flag, a copy of result bit 15 |
| flag_z | output | 1 | Zero flag, set when the result is all zeros |

## Verification
Some additions carry across all 16 slices, such as 0xFFFF + 1 and 0x7FFF + 1. These find a broken link in the chain, and they also set the zero and negative flags at the edges. Subtractions whose result is zero, negative or wrapping show whether the inversion and the forced carry-in are right. For the signed compare, the operand pairs are chosen so that the raw sign of the difference gives the wrong answer (0x8000 against 0x7FFF, and the reverse). These pairs separate a design that corrects for overflow from one that only reads the sign bit or compares unsigned values. Alternating bit masks tell AND from OR from a swapped code. Random operands run under every function code, including the unused codes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int unsigned FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_OR  = 4'd3,
        FN_SLT = 4'd4
    } alu_fn_e;

    // Every value the block produces, gathered for the two-process layout.
    typedef struct packed {
        logic [15:0] res;
        logic        neg;
        logic        zero;
    } alu_out_t;

endpackage

// File: rtl/alu16_slice.sv
// One-bit full adder; every bit position of the chain is this same cell.
module alu16_slice (
    input  logic a_i,
    input  logic b_i,
    input  logic ci_i,
    output logic s_o,
    output logic co_o
);
    logic half_d;

    always_comb begin
        half_d = a_i ^ b_i;
        s_o    = half_d ^ ci_i;
        co_o   = (a_i & b_i) | (half_d & ci_i);
    end
endmodule

// File: rtl/alu16_chain.sv
// Ripple chain of identical slices; sub_i inverts B and forces carry-in high.
module alu16_chain #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] b_eff_d;
    logic [W:0]   cy_d;

    always_comb begin
        b_eff_d = b_i ^ {W{sub_i}};
        cy_d[0] = sub_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu16_slice u_slice (
            .a_i  (a_i[i]),
            .b_i  (b_eff_d[i]),
            .ci_i (cy_d[i]),
            .s_o  (sum_o[i]),
            .co_o (cy_d[i+1])
        );
    end
endmodule

// File: rtl/alu16_flags.sv
// Status flag generation from a finished result word.
module alu16_flags #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] res_i,
    output logic         neg_o,
    output logic         zero_o
);
    localparam int unsigned MSB = W - 1;

    always_comb begin
        neg_o  = res_i[MSB];
        zero_o = ~(|res_i);
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
(
    input  logic [15:0] opa,
    input  logic [15:0] opb,
    input  logic [3:0]  fn,
    output logic [15:0] res,
    output logic        flag_n,
    output logic        flag_z
);
    localparam int unsigned W   = 16;
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] sum_d;
    logic         sub_d;
    logic         ovf_d;
    logic         less_d;
    logic [W-1:0] res_d;
    alu_out_t     out_d;
    logic         neg_d;
    logic         zero_d;

    // Subtract and compare share the chain in inverted-B mode.
    always_comb begin
        sub_d = (fn == FN_SUB) || (fn == FN_SLT);
    end

    alu16_chain #(.W(W)) u_chain (
        .a_i   (opa),
        .b_i   (opb),
        .sub_i (sub_d),
        .sum_o (sum_d)
    );

    // Signed order from the true difference: the sign bit corrected by overflow.
    always_comb begin
        ovf_d  = (opa[MSB] != opb[MSB]) && (sum_d[MSB] != opa[MSB]);
        less_d = sum_d[MSB] ^ ovf_d;
    end

    always_comb begin
        unique case (fn)
            FN_ADD,
            FN_SUB:  res_d = sum_d;
            FN_AND:  res_d = opa & opb;
            FN_OR:   res_d = opa | opb;
            FN_SLT:  res_d = {{(W-1){1'b0}}, less_d};
            default: res_d = '0;
        endcase
    end

    alu16_flags #(.W(W)) u_flags (
        .res_i  (res_d),
        .neg_o  (neg_d),
        .zero_o (zero_d)
    );

    always_comb begin
        out_d.res  = res_d;
        out_d.neg  = neg_d;
        out_d.zero = zero_d;
        res        = out_d.res;
        flag_n     = out_d.neg;
        flag_z     = out_d.zero;
    end
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk (
    input logic [15:0] opa,
    input logic [15:0] opb,
    input logic [3:0]  fn,
    input logic [15:0] res,
    input logic        flag_n,
    input logic        flag_z
);
    logic [15:0] add_ref;
    logic [15:0] sub_ref;

    always_comb begin
        add_ref = opa + opb;
        sub_ref = opa - opb;
        if (!$isunknown({opa, opb, fn, res, flag_n, flag_z})) begin
            if (fn == 4'd0) begin
                assert_add_matches_R1: assert (res == add_ref);
            end
            if (fn == 4'd1) begin
                assert_sub_matches_R2: assert (res == sub_ref);
            end
            if (fn == 4'd4) begin
                assert_slt_signed_R5: assert (res == {15'd0, $signed(opa) < $signed(opb)});
            end
            if (fn > 4'd4) begin
                assert_unused_zero_R6: assert (res == 16'd0);
            end
            assert_zero_flag_R7: assert (flag_z == (res == 16'd0));
            assert_neg_flag_R8: assert (flag_n == res[15]);
        end
    end
endmodule

bind alu16_core alu16_core_chk u_chk (
    .opa    (opa),
    .opb    (opb),
    .fn     (fn),
    .res    (res),
    .flag_n (flag_n),
    .flag_z (flag_z)
);

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;
    logic        clk;
    logic [15:0] opa;
    logic [15:0] opb;
    logic [3:0]  fn;
    logic [15:0] res;
    logic        flag_n;
    logic        flag_z;

    int checks;
    int errors;
    bit done;

    alu16_core dut_i (
        .opa    (opa),
        .opb    (opb),
        .fn     (fn),
        .res    (res),
        .flag_n (flag_n),
        .flag_z (flag_z)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [3:0] f);
        case (f)
            4'd0:    return a + b;
            4'd1:    return a - b;
            4'd2:    return a & b;
            4'd3:    return a | b;
            4'd4:    return ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
            default: return 16'd0;
        endcase
    endfunction

    // Apply after a rising edge, sample at the falling edge; block is combinational.
    task automatic check_op(input logic [15:0] a, input logic [15:0] b,
                            input logic [3:0] f, input string tag);
        logic [15:0] exp;
        @(posedge clk);
        opa = a; opb = b; fn = f;
        @(negedge clk);
        exp = model(a, b, f);
        checks++;
        if (res !== exp) begin
            errors++;
            $display("FAIL %s res fn=%0d a=%h b=%h actual=%h expected=%h", tag, f, a, b, res, exp);
        end
        checks++;
        if (flag_z !== (exp == 16'd0)) begin
            errors++;
            $display("FAIL R7 flag_z fn=%0d a=%h b=%h actual=%b expected=%b", f, a, b, flag_z, exp == 16'd0);
        end
        checks++;
        if (flag_n !== exp[15]) begin
            errors++;
            $display("FAIL R8 flag_n fn=%0d a=%h b=%h actual=%b expected=%b", f, a, b, flag_n, exp[15]);
        end
    endtask

    task automatic test_idle;
        check_op(16'h0000, 16'h0000, 4'd0, "R1");
    endtask

    task automatic test_add;
        check_op(16'hFFFF, 16'h0001, 4'd0, "R1");
        check_op(16'h7FFF, 16'h0001, 4'd0, "R1");
        check_op(16'h1234, 16'h4321, 4'd0, "R1");
        check_op(16'h8000, 16'h8000, 4'd0, "R1");
    endtask

    task automatic test_sub;
        check_op(16'h5A5A, 16'h5A5A, 4'd1, "R2");
        check_op(16'h0000, 16'h0001, 4'd1, "R2");
        check_op(16'h8000, 16'h0001, 4'd1, "R2");
        check_op(16'h0100, 16'h00FF, 4'd1, "R2");
    endtask

    task automatic test_logic;
        check_op(16'hAAAA, 16'h5555, 4'd2, "R3");
        check_op(16'hF0F0, 16'hFF00, 4'd2, "R3");
        check_op(16'hAAAA, 16'h5555, 4'd3, "R4");
        check_op(16'h0000, 16'h0000, 4'd3, "R4");
    endtask

    task automatic test_slt;
        check_op(16'h8000, 16'h7FFF, 4'd4, "R5");
        check_op(16'h7FFF, 16'h8000, 4'd4, "R5");
        check_op(16'hFFFF, 16'h0000, 4'd4, "R5");
        check_op(16'h0001, 16'hFFFF, 4'd4, "R5");
        check_op(16'h1234, 16'h1234, 4'd4, "R5");
        check_op(16'h0003, 16'h0004, 4'd4, "R5");
    endtask

    task automatic test_unused;
        for (int f = 5; f < 16; f++) begin
            check_op(16'hFFFF, 16'h8001, 4'(f), "R6");
        end
    endtask

    task automatic test_random;
        for (int i = 0; i < 300; i++) begin
            logic [3:0] f;
            f = 4'($urandom_range(0, 15));
            check_op(16'($urandom), 16'($urandom), f, "R1-R6 random");
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        checks = 0; errors = 0; done = 1'b0;
        opa = '0; opb = '0; fn = '0;
        test_idle();
        test_add();
        test_sub();
        test_logic();
        test_slt();
        test_unused();
        test_random();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            report();
        end
    end
endmodule